// File: doc/BRIEF.md
# Trimmed One-Second Prescaler

This block turns a stream of oscillator count enables, nominally 32768 per second, into a one-clock pulse once per second. A three-bit trim code corrects a known frequency error of the crystal. The length of any single second is not scaled. Instead, whole counts are occasionally removed from a second or added to it. The average rate then moves by the chosen number of parts per million.

A fractional accumulator holds the correction that has built up, in units of 1/`SCALE` of one oscillator count. At every second boundary it adds the selected ppm magnitude times `NOMINAL`. Each time the total reaches `SCALE`, it subtracts `SCALE` and marks the following second for a one-count change.

For positive compensation that second is one count shorter. For negative compensation it is one count longer. The trim input is only read at a boundary, so a change made partway through a second affects the seconds that follow it.

Top module: `dtrim_second_divider`

## Requirements
- R1: While `rst_n` is low, `sec_pulse` is 0. After reset the accumulator is empty, and the first second is exactly `NOMINAL` counts long.
- R2: With trim code 3'b000 or 3'b100, every second is exactly `NOMINAL` counts long.
- R3: The correction magnitude is 10 ppm when `trim[1]` is set plus 20 ppm when `trim[0]` is set, which gives 0, 10, 20 or 30 ppm. `trim[2]` selects the sign: 0 is positive and 1 is negative.
- R4: At each boundary the accumulator adds magnitude × `NOMINAL` (in 1/`SCALE` counts). When the sum reaches `SCALE`, it subtracts `SCALE` and requests an adjustment for the next second. At most one count is adjusted per second, and the accumulator always stays below `SCALE`.
- R5: An adjusted second lasts `NOMINAL`-1 counts under positive sign and `NOMINAL`+1 counts under negative sign.
- R6: The trim code is sampled only on the enable that ends a second. Changes made at any other time leave the running second unchanged.
- R7: `sec_pulse` is high for exactly one clock, in the cycle after the enable that completes a second.
- R8: Only cycles with `osc_tick` high advance the count. Gaps of any length between enables do not change where a second ends in enable counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One oscillator count when high |
| trim | input | 3 | Trim code: [2] sign, [1] 10 ppm, [0] 20 ppm |
| sec_pulse | output | 1 | One-clock pulse per second |

## Verification
The hardest state to reach is an accumulator carry, because it happens only once every several seconds. It is also hard to see where that carry lands relative to a trim change made mid-second. The bench overrides `NOMINAL` and `SCALE` with small values so that carries occur every few seconds. It then runs tens of seconds for each code and changes the code partway through a second. A bench model predicts, enable by enable, the cycle of every pulse. A closed-form count of how many short seconds must occur gives a second, independent check.

// File: rtl/dtrim_pkg.sv
package dtrim_pkg;
  // ppm magnitude selected by the two scale bits of a trim code
  function automatic int unsigned trim_mag_ppm(input logic [2:0] code,
                                               input int unsigned step);
    int unsigned m;
    m = 0;
    if (code[1]) m = m + step;
    if (code[0]) m = m + 2 * step;
    return m;
  endfunction

  // fractional counts (in 1/SCALE units) added per second
  function automatic int unsigned trim_increment(input int unsigned mag,
                                                 input int unsigned nominal);
    return mag * nominal;
  endfunction
endpackage

// File: rtl/dtrim_decode.sv
module dtrim_decode #(
  parameter int unsigned PPM_STEP = 10,
  parameter int unsigned NOMINAL  = 32768,
  parameter int unsigned INC_W    = 21
) (
  input  logic [2:0]       code,
  output logic             neg,
  output logic [INC_W-1:0] inc
);
  import dtrim_pkg::*;
  always_comb begin
    neg = code[2];
    inc = INC_W'(trim_increment(trim_mag_ppm(code, PPM_STEP), NOMINAL));
  end
endmodule

// File: rtl/dtrim_accum.sv
module dtrim_accum #(
  parameter int unsigned SCALE = 1000000,
  parameter int unsigned INC_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic [INC_W-1:0] inc,
  input  logic             neg,
  output logic             adj_req,
  output logic             adj_neg
);
  localparam int unsigned SUM_W = INC_W + 1;

  logic [INC_W-1:0] acc;
  logic [SUM_W-1:0] sum;
  logic             carry;

  always_comb begin
    sum   = SUM_W'(acc) + SUM_W'(inc);
    carry = (sum >= SUM_W'(SCALE));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      adj_req <= 1'b0;
      adj_neg <= 1'b0;
    end else if (boundary) begin
      acc     <= carry ? INC_W'(sum - SUM_W'(SCALE)) : INC_W'(sum);
      adj_req <= carry;
      adj_neg <= neg;
    end
  end

  // R4: remainder never reaches one whole count
  assert_acc_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc < INC_W'(SCALE));
  // R6: adjustment decision only moves on a boundary
  assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(adj_req) && $stable(adj_neg)));
  // R2: zero correction never schedules an adjustment
  assert_zero_no_adj_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && inc == '0) |=> !adj_req);
endmodule

// File: rtl/dtrim_counter.sv
module dtrim_counter #(
  parameter int unsigned NOMINAL = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic adj_req,
  input  logic adj_neg,
  output logic boundary,
  output logic sec_pulse
);
  localparam int unsigned CNT_W = $clog2(NOMINAL + 2);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb begin
    if (!adj_req)     last = CNT_W'(NOMINAL - 1);
    else if (adj_neg) last = CNT_W'(NOMINAL);
    else              last = CNT_W'(NOMINAL - 2);
    boundary = osc_tick && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      sec_pulse <= 1'b0;
    end else begin
      sec_pulse <= boundary;
      if (boundary)      cnt <= '0;
      else if (osc_tick) cnt <= cnt + 1'b1;
    end
  end

  // R7: pulse is a single clock wide
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);
  // R8: no enable, no second boundary
  assert_idle_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> !sec_pulse);
  // R8: count frozen without an enable
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> $stable(cnt));
  // R5: count never passes the longest period
  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(NOMINAL));
endmodule

// File: rtl/dtrim_second_divider.sv
module dtrim_second_divider #(
  parameter int unsigned NOMINAL  = 32768,
  parameter int unsigned PPM_STEP = 10,
  parameter int unsigned SCALE    = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic [2:0] trim,
  output logic       sec_pulse
);
  localparam int unsigned INC_W = $clog2(SCALE) + 1;

  logic             boundary;
  logic             neg;
  logic [INC_W-1:0] inc;
  logic             adj_req;
  logic             adj_neg;

  dtrim_decode #(.PPM_STEP(PPM_STEP), .NOMINAL(NOMINAL), .INC_W(INC_W)) u_decode (
    .code(trim), .neg(neg), .inc(inc));

  dtrim_accum #(.SCALE(SCALE), .INC_W(INC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .inc(inc), .neg(neg),
    .adj_req(adj_req), .adj_neg(adj_neg));

  dtrim_counter #(.NOMINAL(NOMINAL)) u_counter (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .adj_req(adj_req),
    .adj_neg(adj_neg), .boundary(boundary), .sec_pulse(sec_pulse));

  // R3: the largest increment stays below one whole count
  assert_inc_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc < INC_W'(SCALE));
  // R1: output low throughout reset
  always_ff @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!sec_pulse || $past(rst_n));
  end
endmodule

// File: tb/test_dtrim_second_divider.sv
module test_dtrim_second_divider;
  localparam int CLK_PERIOD = 10;
  localparam int NOM  = 64;
  localparam int STEP = 10;
  localparam int SCL  = 10000;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       osc_tick = 0;
  logic [2:0] trim = 3'b000;
  logic       sec_pulse;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // bench model
  int  m_acc, m_len, m_cnt, m_pulses, m_short, m_long, m_ticks;
  bit  exp_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtrim_second_divider #(.NOMINAL(NOM), .PPM_STEP(STEP), .SCALE(SCL)) i_dtrim_second_divider (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .trim(trim), .sec_pulse(sec_pulse));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int mag_of(input logic [2:0] c);
    return (c[1] ? STEP : 0) + (c[0] ? 2*STEP : 0);
  endfunction

  task automatic model_reset();
    m_acc = 0; m_len = NOM; m_cnt = 0; m_pulses = 0;
    m_short = 0; m_long = 0; m_ticks = 0; exp_prev = 0;
  endtask

  // one clock: check the pulse predicted last clock, then drive
  task automatic step(input bit tick);
    bit e;
    @(negedge clk);
    chk(sec_pulse == exp_prev, cur_req, sec_pulse, exp_prev);
    osc_tick = tick;
    e = 0;
    if (tick) begin
      m_ticks++;
      m_cnt++;
      if (m_cnt == m_len) begin
        e = 1; m_cnt = 0; m_pulses++;
        if (m_len == NOM-1) m_short++;
        if (m_len == NOM+1) m_long++;
        m_acc += mag_of(trim) * NOM;
        if (m_acc >= SCL) begin
          m_acc -= SCL;
          m_len = trim[2] ? NOM+1 : NOM-1;
        end else m_len = NOM;
      end
    end
    exp_prev = e;
  endtask

  task automatic run_seconds(input int n, input int gap);
    int target = m_pulses + n;
    while (m_pulses < target) begin
      step(1);
      for (int g = 0; g < gap; g++) step(0);
    end
    step(0);
  endtask

  task automatic t_reset();
    cur_req = "R1";
    @(negedge clk); rst_n = 0; osc_tick = 0;
    repeat (3) @(negedge clk);
    chk(sec_pulse == 0, "R1", sec_pulse, 0);
    rst_n = 1;
    model_reset();
  endtask

  task automatic t_first_second();
    t_reset();
    trim = 3'b011;
    cur_req = "R1";
    run_seconds(1, 0);
    chk(m_ticks == NOM, "R1", m_ticks, NOM);
  endtask

  task automatic t_zero_codes();
    t_reset(); trim = 3'b000; cur_req = "R2";
    run_seconds(20, 0);
    chk(m_ticks == 20*NOM, "R2", m_ticks, 20*NOM);
    t_reset(); trim = 3'b100; cur_req = "R2";
    run_seconds(20, 1);
    chk(m_ticks == 20*NOM, "R2", m_ticks, 20*NOM);
  endtask

  // closed form: shorts in first n seconds = floor((n-1)*mag*NOM/SCL)
  task automatic t_sign_code(input logic [2:0] c, input int n);
    int adj, exp_ticks;
    t_reset(); trim = c; cur_req = "R5";
    run_seconds(n, 0);
    adj = ((n-1) * mag_of(c) * NOM) / SCL;
    exp_ticks = c[2] ? n*NOM + adj : n*NOM - adj;
    chk(m_ticks == exp_ticks, "R3", m_ticks, exp_ticks);
    chk((c[2] ? m_long : m_short) == adj, "R4", c[2] ? m_long : m_short, adj);
  endtask

  task automatic t_gaps();
    t_reset(); trim = 3'b001; cur_req = "R8";
    run_seconds(12, 3);
    chk(m_ticks == 12*NOM - ((11*2*STEP*NOM)/SCL), "R8", m_ticks,
        12*NOM - ((11*2*STEP*NOM)/SCL));
  endtask

  task automatic t_mid_change();
    t_reset(); trim = 3'b011; cur_req = "R6";
    for (int k = 0; k < 30; k++) step(1);
    trim = 3'b111;
    for (int k = 0; k < 20; k++) step(1);
    trim = 3'b000;
    for (int k = 0; k < 13; k++) step(1);
    trim = 3'b111;
    step(1);
    step(0);
    chk(m_pulses == 1, "R6", m_pulses, 1);
    run_seconds(40, 0);
    chk(m_long > 0, "R6", m_long, 1);
    chk(m_short == 0, "R6", m_short, 0);
  endtask

  initial begin
    model_reset();
    t_reset();
    t_first_second();
    t_zero_codes();
    t_sign_code(3'b010, 40);
    t_sign_code(3'b001, 40);
    t_sign_code(3'b011, 40);
    t_sign_code(3'b110, 40);
    t_sign_code(3'b101, 40);
    t_sign_code(3'b111, 40);
    t_gaps();
    t_mid_change();
    cur_req = "R7";
    for (int k = 0; k < 5; k++) step(0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule